// File: doc/BRIEF.md
# Catastrophic error pin signaller

This block manages one shared, active-low catastrophic-error line that every agent in a system joins as a wired-OR. The block never drives the line high. It only asks the pad to pull it low, through `pin_pull`, or lets it go. Two kinds of internal event can assert the line:

- A machine-check-class error pulls the line low for a fixed number of base-clock cycles and then releases it.
- An unrecoverable internal error pulls the line low and keeps it low until a warm reset or a cold reset.

The block also watches the resolved level of the line. Another agent may pull the line low while this block is not pulling it. In that case the block raises a one-cycle machine-check exception request. The line is only believed once power-good is high. Dropping power-good clears all state and releases the line.

The line input goes through a synchroniser. A matching delay line of the block's own pull request is kept beside it, so the tail of a self-assertion is never mistaken for an external one.

Top module: `caterr_signaller`

## Requirements
- R1: After the synchronous reset, `pin_pull` and `mce_req` are both 0.
- R2: With power-good high, a one-cycle `mce_evt` makes `pin_pull` 1 from the next cycle onward, for exactly PULSE_CYCLES cycles (16 by default). After that it returns to 0.
- R3: An `mce_evt` that arrives while a pulse is running restarts the count. The line stays pulled for PULSE_CYCLES cycles after the later event.
- R4: An `ierr_evt` with power-good high makes `pin_pull` 1 from the next cycle. It stays 1 for as long as no warm reset, cold reset or power-good loss occurs.
- R5: An `ierr_evt` during a running pulse keeps `pin_pull` at 1 after the pulse count has run out.
- R6: A `warm_rst` or `cold_rst` cycle clears both the pulse and the held level. `pin_pull` is 0 on the next cycle, and this takes priority over events in the same cycle.
- R7: While `pwr_good` is 0, `pin_pull` is 0 from the next cycle and `mce_req` stays 0. Events and line level are ignored in that time.
- R8: The line is read low (`pin_in` = 0) while the block is not pulling it and power-good is high. `mce_req` is then 1 for a single cycle, three rising edges after the first edge that sees the low level (two synchroniser stages plus one output register).
- R9: The block's own assertions of the line, including the release tail, never raise `mce_req`.
- R10: An external assertion held low across many cycles gives only one request. A line already low when power-good rises gives one request, on the edge after power-good is seen high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous reset, active high |
| pwr_good | input | 1 | Power-good qualifier, active high |
| warm_rst | input | 1 | Warm reset pulse, active high |
| cold_rst | input | 1 | Cold reset pulse, active high |
| mce_evt | input | 1 | Machine-check-class error event, one cycle |
| ierr_evt | input | 1 | Unrecoverable internal error event, one cycle |
| pin_in | input | 1 | Resolved level of the shared line (0 = asserted) |
| pin_pull | output | 1 | 1 = pull the shared line low, 0 = release it |
| mce_req | output | 1 | One-cycle machine-check exception request |

## Verification
A wrong pulse count shows at `pin_pull` within at most PULSE_CYCLES+1 cycles of an event, as a release one cycle too early or too late. A held latch that fails to set or clear shows on the very next cycle. A delay line of the block's own pull that is out of step with the synchroniser appears three edges after a release, as a spurious `mce_req`. A lost edge detector shows as repeated requests while an agent holds the line low. The bench keeps its own behavioural model of the line, the count and the sampled history, and it compares both outputs against that model every cycle. Directed scenarios then count pulse lengths and request totals.

// File: rtl/caterr_pkg.sv
package caterr_pkg;
  localparam int unsigned CATERR_PULSE_DEF = 16;
  localparam int unsigned CATERR_SYNC_DEF  = 2;

  typedef struct packed {
    logic pulse;
    logic hold;
  } caterr_drive_t;
endpackage

// File: rtl/caterr_pulse_timer.sv
module caterr_pulse_timer #(
  parameter int unsigned PULSE_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic load,
  output logic active
);
  localparam int unsigned CNT_W = $clog2(PULSE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(PULSE_CYCLES);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)       cnt <= '0;
    else if (load)        cnt <= CNT_FULL;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign active = (cnt != '0);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_FULL); // R2
  AST_CNT_STEPS: assert property (@(posedge clk) disable iff (rst)
    (active && !load && !clr) |=> (cnt == $past(cnt) - 1'b1)); // R2
endmodule

// File: rtl/caterr_hold_latch.sv
module caterr_hold_latch (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic set,
  output logic held
);
  always_ff @(posedge clk) begin
    if (rst || clr) held <= 1'b0;
    else if (set)   held <= 1'b1;
  end

  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (held && !clr) |=> held); // R4
endmodule

// File: rtl/caterr_ext_detect.sv
module caterr_ext_detect #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_good,
  input  logic pin_in,
  input  logic self_pull,
  output logic req
);
  logic [SYNC_STAGES-1:0] pin_sync;
  logic [SYNC_STAGES-1:0] pull_dly;
  logic                   ext_prev;
  logic                   ext_low;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_sync <= '1;
      pull_dly <= '0;
    end else begin
      pin_sync <= {pin_sync[SYNC_STAGES-2:0], pin_in};
      pull_dly <= {pull_dly[SYNC_STAGES-2:0], self_pull};
    end
  end

  assign ext_low = pwr_good && !pin_sync[SYNC_STAGES-1] && !pull_dly[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_prev <= 1'b0;
      req      <= 1'b0;
    end else begin
      ext_prev <= ext_low;
      req      <= ext_low && !ext_prev;
    end
  end

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    req |=> !req); // R10
  AST_REQ_NEEDS_PG: assert property (@(posedge clk) disable iff (rst)
    req |-> $past(pwr_good)); // R7
endmodule

// File: rtl/caterr_signaller.sv
module caterr_signaller
  import caterr_pkg::*;
#(
  parameter int unsigned PULSE_CYCLES = CATERR_PULSE_DEF,
  parameter int unsigned SYNC_STAGES  = CATERR_SYNC_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_good,
  input  logic warm_rst,
  input  logic cold_rst,
  input  logic mce_evt,
  input  logic ierr_evt,
  input  logic pin_in,
  output logic pin_pull,
  output logic mce_req
);
  caterr_drive_t drv;
  logic          clr_all;

  assign clr_all = !pwr_good || warm_rst || cold_rst;

  caterr_pulse_timer #(.PULSE_CYCLES(PULSE_CYCLES)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .clr    (clr_all),
    .load   (mce_evt),
    .active (drv.pulse)
  );

  caterr_hold_latch u_hold (
    .clk  (clk),
    .rst  (rst),
    .clr  (clr_all),
    .set  (ierr_evt),
    .held (drv.hold)
  );

  // Output decoded from registers only; the pad pulls low when set.
  assign pin_pull = drv.pulse | drv.hold;

  caterr_ext_detect #(.SYNC_STAGES(SYNC_STAGES)) u_detect (
    .clk       (clk),
    .rst       (rst),
    .pwr_good  (pwr_good),
    .pin_in    (pin_in),
    .self_pull (pin_pull),
    .req       (mce_req)
  );

  AST_MCE_PULLS: assert property (@(posedge clk) disable iff (rst)
    (mce_evt && !clr_all) |=> pin_pull); // R2
  AST_IERR_PULLS: assert property (@(posedge clk) disable iff (rst)
    (ierr_evt && !clr_all) |=> (pin_pull && drv.hold)); // R4
  AST_CLR_RELEASES: assert property (@(posedge clk) disable iff (rst)
    (warm_rst || cold_rst) |=> !pin_pull); // R6
  AST_PG_RELEASES: assert property (@(posedge clk) disable iff (rst)
    !pwr_good |=> (!pin_pull && !mce_req)); // R7
endmodule

// File: tb/sim_caterr_signaller.sv
module sim_caterr_signaller;
  localparam int CLK_PERIOD = 10;
  localparam int PULSE = 16;

  logic clk = 1'b0;
  logic rst, pwr_good, warm_rst, cold_rst, mce_evt, ierr_evt, ext_drv;
  logic pin_pull, mce_req;
  wire  pin_w = ~(pin_pull | ext_drv);

  int checks = 0;
  int fails  = 0;
  int pull_tally = 0;
  int req_tally  = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  caterr_signaller u0 (
    .clk(clk), .rst(rst), .pwr_good(pwr_good), .warm_rst(warm_rst),
    .cold_rst(cold_rst), .mce_evt(mce_evt), .ierr_evt(ierr_evt),
    .pin_in(pin_w), .pin_pull(pin_pull), .mce_req(mce_req)
  );

  // Behavioural reference: line history, pulse count, held flag.
  int m_cnt;
  bit m_held, m_pull, m_req, m_q, m_s1, m_s2, m_p1, m_p2;
  always @(posedge clk) begin
    bit qual;
    if (rst) begin
      m_cnt = 0; m_held = 0; m_s1 = 1; m_s2 = 1; m_p1 = 0; m_p2 = 0;
      m_q = 0; m_req = 0;
    end else begin
      qual  = pwr_good && !m_s2 && !m_p2;
      m_req = qual && !m_q;
      m_q   = qual;
      m_s2 = m_s1; m_s1 = !(m_pull || ext_drv);
      m_p2 = m_p1; m_p1 = m_pull;
      if (!pwr_good || warm_rst || cold_rst) begin
        m_cnt = 0; m_held = 0;
      end else begin
        if (mce_evt) m_cnt = PULSE;
        else if (m_cnt > 0) m_cnt = m_cnt - 1;
        if (ierr_evt) m_held = 1;
      end
    end
    m_pull = (m_cnt != 0) || m_held;
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (pin_pull !== m_pull || mce_req !== m_req) begin
        fails++;
        $display("FAIL R2/R8 model: pull=%0b req=%0b expected pull=%0b req=%0b",
                 pin_pull, mce_req, m_pull, m_req);
      end
      if (pin_pull) pull_tally++;
      if (mce_req)  req_tally++;
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin
      @(negedge clk);
      #(CLK_PERIOD/4);
    end
  endtask

  task automatic check(string tag, int actual, int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
    end
  endtask

  task automatic pulse_in(ref logic sig);
    sig = 1'b1; tick(); sig = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int p0, r0;
    rst = 1; pwr_good = 1; warm_rst = 0; cold_rst = 0;
    mce_evt = 0; ierr_evt = 0; ext_drv = 0;
    tick(3); rst = 0; tick();
    check("R1 pull after reset", pin_pull, 0);
    check("R1 req after reset", mce_req, 0);

    // R2 single pulse length, R9 no self request
    p0 = pull_tally; r0 = req_tally;
    pulse_in(mce_evt); tick(30);
    check("R2 pulse length", pull_tally - p0, PULSE);
    check("R9 no req from own pulse", req_tally - r0, 0);

    // R3 restart during pulse
    p0 = pull_tally;
    pulse_in(mce_evt); tick(4); pulse_in(mce_evt); tick(30);
    check("R3 restarted length", pull_tally - p0, PULSE + 5);

    // R4 held level, R6 warm reset clears
    r0 = req_tally;
    pulse_in(ierr_evt); tick(40);
    check("R4 held after 40 cycles", pin_pull, 1);
    pulse_in(warm_rst);
    check("R6 warm reset releases", pin_pull, 0);
    tick(5);
    check("R9 no req after held release", req_tally - r0, 0);

    // R5 ierr during pulse, R6 cold reset with simultaneous event
    pulse_in(mce_evt); tick(3); pulse_in(ierr_evt); tick(30);
    check("R5 held past pulse end", pin_pull, 1);
    mce_evt = 1; cold_rst = 1; tick(); mce_evt = 0; cold_rst = 0;
    check("R6 cold reset wins over event", pin_pull, 0);
    tick(5);

    // R7 power-good low: clears hold, ignores events and line
    pulse_in(ierr_evt); tick(2);
    pwr_good = 0; tick();
    check("R7 pg loss releases", pin_pull, 0);
    r0 = req_tally; p0 = pull_tally;
    pulse_in(mce_evt); pulse_in(ierr_evt);
    ext_drv = 1; tick(10);
    check("R7 events ignored without pg", pull_tally - p0, 0);
    check("R7 no req without pg", req_tally - r0, 0);

    // R10 line already low when pg rises: one request
    pwr_good = 1; tick();
    check("R10 req on pg rise", mce_req, 1);
    tick(10);
    check("R10 single req on pg rise", req_tally - r0, 1);
    ext_drv = 0; tick(5);

    // R8 latency of external detection, R10 held low gives one request
    r0 = req_tally;
    ext_drv = 1; tick(2);
    check("R8 no req after two edges", mce_req, 0);
    tick();
    check("R8 req after three edges", mce_req, 1);
    tick();
    check("R8 req lasts one cycle", mce_req, 0);
    tick(20);
    check("R10 one req for long hold", req_tally - r0, 1);
    ext_drv = 0; tick(5);

    // R9 external agent overlapping own pulse: no extra request
    r0 = req_tally;
    pulse_in(mce_evt); tick(2); ext_drv = 1; tick(3); ext_drv = 0; tick(30);
    check("R9 overlap hidden by own pull", req_tally - r0, 0);

    finish_run();
  end
endmodule